// File: doc/BRIEF.md
# Data Link Up/Down Control Sequencer

This block decides whether a serial link's data link layer is operational. It watches the physical layer's link-good indication and walks through four states: a quiet disconnected state, an optional capability-exchange state, a two-phase credit-initialisation state and a running state. The state and its phase drive a set of gates. These gates allow or block traffic of link-control packets and transaction packets in each direction. The block also reports an up/down status to the layers above.

A separate credit-initialisation sequencer does the packet work. This block starts that sequencer with a one-cycle strobe and moves forward when the sequencer reports that each phase is done. Credit setup here covers only the default virtual channel, number 0. When the physical link drops, the block returns to the disconnected state on the next clock edge. On that same edge it emits a one-cycle pulse telling the retransmit store to empty itself. A build parameter can remove the capability-exchange state completely.

Top module: `dl_link_ctrl`

## Requirements
- R1: After reset the block is Disconnected: `link_is_up`=0, `drop_pending`=1, all four traffic gates 0, `xchg_busy`=0, `flush_retry`=0, `fc_start`=0.
- R2: While `phy_link_up`=0, the block stays Disconnected and ignores `xchg_en` and all done inputs.
- R3: With `FEATURE_SUPPORT`=1, `phy_link_up`=1 and `xchg_en`=1 in Disconnected, the block enters Exchange on the next edge. Exchange drives `xchg_busy`=1, `link_is_up`=0 and all gates 0.
- R4: When `phy_link_up`=1 and `xchg_en`=0 in Disconnected, the block enters Credit phase 1 directly. Each entry into Credit phase 1 raises `fc_start` for exactly one cycle.
- R5: In Exchange, `xchg_done`=1 moves the block to Credit phase 1.
- R6: Credit phase 1 drives `link_is_up`=0, both link-control gates 1 and both transaction gates 0. `fc1_done`=1 moves the block to Credit phase 2. Credit phase 2 drives `link_is_up`=1 with the same gate pattern.
- R7: In Credit phase 2, `fc2_done`=1 moves the block to Running. Running drives `link_is_up`=1 and all four gates 1. Credit setup targets only channel 0 (`fc_vc`=0).
- R8: If `phy_link_up`=0 in any state other than Disconnected, the block is Disconnected after the next edge, and `flush_retry` is 1 for exactly that one cycle.
- R9: A done input is ignored unless the block is in the state that waits for it. For example, `fc2_done` has no effect in Credit phase 1, and `fc1_done` and `fc2_done` have no effect in Exchange.
- R10: With `FEATURE_SUPPORT`=0, `xchg_en` is ignored. Link-up leads straight to Credit phase 1, and `xchg_busy` stays 0.
- R11: `drop_pending` is 1 exactly while the block is Disconnected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phy_link_up | input | 1 | Physical layer reports a usable link |
| xchg_en | input | 1 | Capability exchange requested |
| xchg_done | input | 1 | Capability exchange finished |
| fc1_done | input | 1 | Credit sequencer finished phase 1 |
| fc2_done | input | 1 | Credit sequencer finished phase 2 |
| link_is_up | output | 1 | Data link status, 1 = up |
| flush_retry | output | 1 | One-cycle request to empty the retransmit store |
| drop_pending | output | 1 | Discard outstanding transactions (held while disconnected) |
| dllp_tx_en | output | 1 | Link-control packet transmit allowed |
| dllp_rx_en | output | 1 | Link-control packet receive allowed |
| tlp_tx_en | output | 1 | Transaction packet transmit allowed |
| tlp_rx_en | output | 1 | Transaction packet receive allowed |
| fc_start | output | 1 | One-cycle strobe that starts credit initialisation |
| fc_phase2 | output | 1 | Credit sequencer should run phase 2 |
| fc_vc | output | VC_W | Virtual channel being initialised (always 0) |
| xchg_busy | output | 1 | Capability exchange in progress |

## Verification
The assertions assume that the sequencer pulses the done inputs, or holds them, only as acknowledgements. They also assume that `phy_link_up` is synchronous to `clk`. The assertions that tie a status rise to an earlier done input work because the block must never change state without that input. The stimulus drives every input at the falling edge. It deliberately raises done inputs in the wrong states and while the link is down, so the ignore rules are exercised without breaking the synchronous-input assumption.

// File: rtl/dl_link_ctrl_pkg.sv
package dl_link_ctrl_pkg;

   typedef enum logic [2:0] {
      LS_DISC  = 3'd0,
      LS_XCHG  = 3'd1,
      LS_FC1   = 3'd2,
      LS_FC2   = 3'd3,
      LS_RUN   = 3'd4
   } link_state_e;

   typedef struct packed {
      logic up;
      logic drop;
      logic dllp_gate;
      logic tlp_gate;
      logic xchg;
      logic phase2;
   } link_gates_t;

endpackage

// File: rtl/dl_link_next.sv
module dl_link_next
   import dl_link_ctrl_pkg::*;
#(
   parameter int FEATURE_SUPPORT = 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  link_state_e state_q,
   input  logic        phy_link_up,
   input  logic        xchg_en,
   input  logic        xchg_done,
   input  logic        fc1_done,
   input  logic        fc2_done,
   output link_state_e state_nx
);

   logic feat_go;

   generate
      if (FEATURE_SUPPORT != 0) begin : g_feat
         assign feat_go = xchg_en;
      end else begin : g_nofeat
         assign feat_go = 1'b0;
      end
   endgenerate

   always_comb begin
      state_nx = state_q;
      if (!phy_link_up) begin
         state_nx = LS_DISC;
      end else begin
         unique case (state_q)
            LS_DISC: state_nx = feat_go ? LS_XCHG : LS_FC1;
            LS_XCHG: if (xchg_done) state_nx = LS_FC1;
            LS_FC1:  if (fc1_done)  state_nx = LS_FC2;
            LS_FC2:  if (fc2_done)  state_nx = LS_RUN;
            LS_RUN:  state_nx = LS_RUN;
            default: state_nx = LS_DISC;
         endcase
      end
   end

   // R10: without the feature, the exchange state is never reached
   generate
      if (FEATURE_SUPPORT == 0) begin : g_chk_nofeat
         assert_no_xchg_R10: assert property (@(posedge clk) disable iff (!rst_n)
            state_q != LS_XCHG);
      end
   endgenerate

   // R2: with the link down, the block stays disconnected
   assert_disc_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == LS_DISC && !phy_link_up) |=> (state_q == LS_DISC));

endmodule

// File: rtl/dl_link_gates.sv
module dl_link_gates
   import dl_link_ctrl_pkg::*;
(
   input  link_state_e state_q,
   output link_gates_t gates
);

   always_comb begin
      gates = '0;
      unique case (state_q)
         LS_DISC: gates.drop = 1'b1;
         LS_XCHG: gates.xchg = 1'b1;
         LS_FC1:  gates.dllp_gate = 1'b1;
         LS_FC2: begin
            gates.dllp_gate = 1'b1;
            gates.up        = 1'b1;
            gates.phase2    = 1'b1;
         end
         LS_RUN: begin
            gates.dllp_gate = 1'b1;
            gates.tlp_gate  = 1'b1;
            gates.up        = 1'b1;
         end
         default: gates.drop = 1'b1;
      endcase
   end

endmodule

// File: rtl/dl_link_pulse.sv
module dl_link_pulse
   import dl_link_ctrl_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  link_state_e state_q,
   input  link_state_e state_nx,
   input  logic        phy_link_up,
   output logic        flush_retry,
   output logic        fc_start
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flush_retry <= 1'b0;
         fc_start    <= 1'b0;
      end else begin
         flush_retry <= (state_q != LS_DISC) && !phy_link_up;
         fc_start    <= (state_nx == LS_FC1) && (state_q != LS_FC1);
      end
   end

   assert_flush_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flush_retry |=> !flush_retry);

   assert_fcstart_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fc_start |=> !fc_start);

   assert_fcstart_in_fc1_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fc_start |-> (state_q == LS_FC1));

endmodule

// File: rtl/dl_link_ctrl.sv
module dl_link_ctrl
   import dl_link_ctrl_pkg::*;
#(
   parameter int FEATURE_SUPPORT = 1,
   parameter int NUM_VC          = 1,
   localparam int VC_W           = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            phy_link_up,
   input  logic            xchg_en,
   input  logic            xchg_done,
   input  logic            fc1_done,
   input  logic            fc2_done,
   output logic            link_is_up,
   output logic            flush_retry,
   output logic            drop_pending,
   output logic            dllp_tx_en,
   output logic            dllp_rx_en,
   output logic            tlp_tx_en,
   output logic            tlp_rx_en,
   output logic            fc_start,
   output logic            fc_phase2,
   output logic [VC_W-1:0] fc_vc,
   output logic            xchg_busy
);

   initial begin
      assert (FEATURE_SUPPORT == 0 || FEATURE_SUPPORT == 1)
         else $error("FEATURE_SUPPORT must be 0 or 1");
      assert (NUM_VC >= 1)
         else $error("NUM_VC must be at least 1");
   end

   link_state_e state_q, state_nx;
   link_gates_t gates;

   dl_link_next #(.FEATURE_SUPPORT(FEATURE_SUPPORT)) u_next (
      .clk        (clk),
      .rst_n      (rst_n),
      .state_q    (state_q),
      .phy_link_up(phy_link_up),
      .xchg_en    (xchg_en),
      .xchg_done  (xchg_done),
      .fc1_done   (fc1_done),
      .fc2_done   (fc2_done),
      .state_nx   (state_nx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= LS_DISC;
      else        state_q <= state_nx;
   end

   dl_link_gates u_gates (
      .state_q(state_q),
      .gates  (gates)
   );

   dl_link_pulse u_pulse (
      .clk        (clk),
      .rst_n      (rst_n),
      .state_q    (state_q),
      .state_nx   (state_nx),
      .phy_link_up(phy_link_up),
      .flush_retry(flush_retry),
      .fc_start   (fc_start)
   );

   assign link_is_up   = gates.up;
   assign drop_pending = gates.drop;
   assign dllp_tx_en   = gates.dllp_gate;
   assign dllp_rx_en   = gates.dllp_gate;
   assign tlp_tx_en    = gates.tlp_gate;
   assign tlp_rx_en    = gates.tlp_gate;
   assign xchg_busy    = gates.xchg;
   assign fc_phase2    = gates.phase2;
   assign fc_vc        = '0;   // R7: only the default channel is set up

   assert_linkdrop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!phy_link_up && state_q != LS_DISC) |=> (drop_pending && flush_retry));

   assert_up_after_fc1_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(link_is_up) |-> $past(fc1_done && phy_link_up));

   assert_run_after_fc2_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tlp_tx_en) |-> $past(fc2_done && link_is_up));

   assert_xchg_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(xchg_busy) && !drop_pending |-> $past(xchg_done) && fc_start);

   assert_disc_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drop_pending) |-> flush_retry);

endmodule

// File: tb/dl_link_ctrl_test.sv
module dl_link_ctrl_test;

   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic phy_link_up = 1'b0, xchg_en = 1'b0, xchg_done = 1'b0;
   logic fc1_done = 1'b0, fc2_done = 1'b0;

   logic link_is_up, flush_retry, drop_pending, dllp_tx_en, dllp_rx_en;
   logic tlp_tx_en, tlp_rx_en, fc_start, fc_phase2, xchg_busy;
   logic [0:0] fc_vc;
   logic n_up, n_flush, n_drop, n_dtx, n_drx, n_ttx, n_trx, n_start, n_ph2, n_busy;
   logic [0:0] n_vc;

   int checks = 0;
   int fails  = 0;
   bit done_flag = 0;

   // Expected vector: [8]up [7]flush [6]drop [5]dllp_tx [4]dllp_rx
   //                  [3]tlp_tx [2]tlp_rx [1]fc_start [0]xchg_busy
   logic [8:0] exp_q[$];
   string      tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   dl_link_ctrl uut (
      .clk(clk), .rst_n(rst_n), .phy_link_up(phy_link_up), .xchg_en(xchg_en),
      .xchg_done(xchg_done), .fc1_done(fc1_done), .fc2_done(fc2_done),
      .link_is_up(link_is_up), .flush_retry(flush_retry), .drop_pending(drop_pending),
      .dllp_tx_en(dllp_tx_en), .dllp_rx_en(dllp_rx_en), .tlp_tx_en(tlp_tx_en),
      .tlp_rx_en(tlp_rx_en), .fc_start(fc_start), .fc_phase2(fc_phase2),
      .fc_vc(fc_vc), .xchg_busy(xchg_busy)
   );

   dl_link_ctrl #(.FEATURE_SUPPORT(0)) uut_nf (
      .clk(clk), .rst_n(rst_n), .phy_link_up(phy_link_up), .xchg_en(xchg_en),
      .xchg_done(xchg_done), .fc1_done(fc1_done), .fc2_done(fc2_done),
      .link_is_up(n_up), .flush_retry(n_flush), .drop_pending(n_drop),
      .dllp_tx_en(n_dtx), .dllp_rx_en(n_drx), .tlp_tx_en(n_ttx),
      .tlp_rx_en(n_trx), .fc_start(n_start), .fc_phase2(n_ph2),
      .fc_vc(n_vc), .xchg_busy(n_busy)
   );

   function automatic logic [8:0] observed();
      return {link_is_up, flush_retry, drop_pending, dllp_tx_en, dllp_rx_en,
              tlp_tx_en, tlp_rx_en, fc_start, xchg_busy};
   endfunction

   task automatic check(string tag, logic [8:0] act, logic [8:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %b expected %b", tag, act, exp);
      end
   endtask

   // driver: apply inputs at the falling edge, queue what the next edge must give
   task automatic step(logic lu, logic xe, logic xd, logic f1, logic f2,
                       logic [8:0] exp, string tag);
      @(negedge clk);
      phy_link_up = lu; xchg_en = xe; xchg_done = xd; fc1_done = f1; fc2_done = f2;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
   endtask

   // monitor
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) check(tag_q.pop_front(), observed(), exp_q.pop_front());
      end
   end

   localparam logic [8:0] V_DISC  = 9'h040;
   localparam logic [8:0] V_FLUSH = 9'h0C0;
   localparam logic [8:0] V_XCHG  = 9'h001;
   localparam logic [8:0] V_FC1S  = 9'h032;
   localparam logic [8:0] V_FC1   = 9'h030;
   localparam logic [8:0] V_FC2   = 9'h130;
   localparam logic [8:0] V_RUN   = 9'h13C;

   initial begin
      #(CLK_PERIOD * 5000);
      if (!done_flag) begin
         fails++; checks++;
         $display("FAIL watchdog: got hang expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R1 reset", observed(), V_DISC);
      check("R1 reset phase/vc", {7'd0, fc_phase2, fc_vc}, 9'd0);
      @(negedge clk);
      rst_n = 1'b1;

      step(0, 1, 1, 1, 1, V_DISC,  "R2 link down ignores inputs");
      step(0, 0, 0, 1, 0, V_DISC,  "R2 link down hold");
      step(1, 1, 0, 0, 0, V_XCHG,  "R3 enter exchange");
      @(posedge clk); #2;
      check("R10 no-feature variant skips exchange",
            {n_up, n_flush, n_drop, n_dtx, n_drx, n_ttx, n_trx, n_start, n_busy}, V_FC1S);
      step(1, 1, 0, 1, 1, V_XCHG,  "R9 fc dones ignored in exchange");
      step(1, 0, 1, 0, 0, V_FC1S,  "R5 exchange done to phase 1");
      step(1, 0, 0, 0, 1, V_FC1,   "R9 fc2_done ignored in phase 1");
      step(1, 0, 0, 0, 0, V_FC1,   "R6 phase 1 hold");
      step(1, 0, 0, 1, 0, V_FC2,   "R6 phase 2 reports up");
      @(posedge clk); #2;
      check("R7 vc and phase2 flag", {7'd0, fc_phase2, fc_vc}, 9'd2);
      step(1, 0, 0, 0, 0, V_FC2,   "R6 phase 2 hold");
      step(1, 0, 0, 0, 1, V_RUN,   "R7 enter running");
      step(1, 1, 1, 1, 0, V_RUN,   "R7 running hold");
      step(0, 0, 0, 0, 0, V_FLUSH, "R8 drop from running");
      step(0, 0, 0, 0, 0, V_DISC,  "R8 R11 flush single cycle");
      step(1, 0, 0, 0, 0, V_FC1S,  "R4 direct to phase 1");
      step(1, 0, 0, 0, 0, V_FC1,   "R4 start strobe single");
      step(0, 0, 0, 0, 0, V_FLUSH, "R8 drop from phase 1");
      step(1, 1, 0, 0, 0, V_XCHG,  "R3 exchange again");
      step(0, 1, 0, 0, 0, V_FLUSH, "R8 drop from exchange");
      step(1, 0, 0, 0, 0, V_FC1S,  "R4 phase 1 again");
      step(1, 0, 0, 1, 0, V_FC2,   "R6 phase 2 again");
      step(0, 0, 0, 0, 0, V_FLUSH, "R8 drop from phase 2");
      step(0, 0, 0, 0, 0, V_DISC,  "R11 disconnected hold");

      @(negedge clk);
      @(negedge clk);
      done_flag = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule